// File: doc/BRIEF.md
# Bit-level serial ROM responder

This block sits behind a software-driven two-wire bus and plays the part of a 256-byte read-only serial memory. The master does not drive a real bus. It presents a new pair of clock and data levels together with a one-cycle update strobe. The block reports back, on a single output, the data level it currently holds. That level is the master's own level, or the level the block forced in place of it.

Each update is compared with the clock and data levels stored from the previous update. A data change while the clock stays high is a bus START or STOP.

After a START the block works through three steps:
- It collects a control byte and acknowledges it.
- It collects an address byte. When the control byte asks for a read, it shifts out the byte it loaded last, one bit per clock edge.
- It loads the newly addressed byte, acknowledges, and falls back to idle.

The memory contents are fixed at build time by a seed parameter. Nothing can write them.

Top module: `serial_rom_slave`

## Requirements
- R1: The store holds 256 bytes, selected by an 8-bit address. Byte i holds (i*29 + SEED) mod 256, and SEED defaults to 90.
- R2: After synchronous active-low reset, sda_o is 1, the position counter is 0 and no acknowledge is pending.
- R3: When upd_i is 0, the clock and data inputs have no effect and sda_o holds its value.
- R4: On an update where scl_i is 1 and the stored clock is also 1 but sda_i differs from the stored data, the block sees a STOP if sda_i is 1. It sees a START if sda_i is 0, and a START sets the position counter to 1 and clears the control byte. This holds at any position, including in the middle of a byte.
- R5: While the counter is 0 and no acknowledge is pending, every update other than a START or STOP is ignored, apart from recording the levels.
- R6: A bit is taken only on a rising clock (stored clock 0, scl_i 1) and only when sda_i equals the stored data level. If data changes in the same update as the clock rises, no bit is taken.
- R7: On a rising clock with an acknowledge pending, the block records data as 0 whatever the master drives, clears the pending flag and takes no bit.
- R8: At positions 1 to 8, taken bits enter the control byte MSB first. When the counter reaches 9, an acknowledge becomes pending. Bit 0 of the control byte selects read (1) or write (0).
- R9: At positions 9 to 16, taken bits enter the address MSB first. In read mode the recorded data level is replaced by the top bit of the data register, which then shifts left. In write mode the master's level stays.
- R10: When the counter reaches 17, the data register loads the addressed byte, an acknowledge becomes pending and the counter returns to 0.
- R11: sda_o always equals the data level recorded at the last update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe: scl_i and sda_i are sampled when high |
| scl_i | input | 1 | Bus clock level presented by the master |
| sda_i | input | 1 | Bus data level presented by the master |
| sda_o | output | 1 | Data level recorded by the block |

## Verification
The master is driven through several patterns:
- Clocking with no START shows the idle path only echoes levels.
- Two back-to-back read transactions show the read data lags one transaction behind the address that selects it. The first read returns the reset data register (zero). The second returns the byte at the earlier address.
- A write-mode transaction shows the echoed bits are the master's own. Its address still decides what the next read returns, which covers the top address 0xFF.
- A data edge coinciding with a rising clock, a repeated START in the middle of a byte, and idle cycles with the strobe low each break the bit alignment if handled wrongly. The following read shows that through the byte it returns.

// File: rtl/srs_pkg.sv
// Shared definitions for the serial ROM responder.
// Assumes a byte-wide address so one address byte selects the whole store.
package srs_pkg;

    // Classification of one update against the previously stored levels.
    typedef enum logic [2:0] {
        EV_NONE,       // no update this cycle
        EV_START,      // data fell while clock stayed high
        EV_STOP,       // data rose while clock stayed high
        EV_RISE_SAME,  // clock rose, data unchanged
        EV_RISE_CHG,   // clock rose, data changed with it
        EV_OTHER       // any other level update
    } bus_ev_t;

    // Content of the store at one index.
    function automatic logic [7:0] rom_value(input int idx, input int seed);
        int v;
        v = idx * 29 + seed;
        return v[7:0];
    endfunction

endpackage

// File: rtl/srs_event_decode.sv
// Event decoder: classifies an update by comparing the new clock and data
// levels with the ones stored at the previous update.
// Assumes the stored levels come from the engine registers.
module srs_event_decode
    import srs_pkg::*;
(
    input  logic    upd_i,
    input  logic    prev_scl,
    input  logic    prev_sda,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    // Purpose: pick the single event class for this cycle.
    always_comb begin
        if (!upd_i)
            ev_o = EV_NONE;
        else if (prev_scl && scl_i && (prev_sda != sda_i))
            ev_o = sda_i ? EV_STOP : EV_START;
        else if (!prev_scl && scl_i)
            ev_o = (prev_sda == sda_i) ? EV_RISE_SAME : EV_RISE_CHG;
        else
            ev_o = EV_OTHER;
    end

endmodule

// File: rtl/srs_rom.sv
// Constant store: combinational lookup into a table computed from SEED.
// Assumes the address is valid in the same cycle as the read.
module srs_rom #(
    parameter int BYTE_W = 8,
    parameter int SEED   = 90
) (
    input  logic [BYTE_W-1:0] addr_i,
    output logic [BYTE_W-1:0] data_o
);

    localparam int DEPTH = 1 << BYTE_W;

    logic [BYTE_W-1:0] table_w [DEPTH];

    // Build one constant entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_w[i] = BYTE_W'(srs_pkg::rom_value(i, SEED));
    end

    assign data_o = table_w[addr_i];

endmodule

// File: rtl/srs_engine.sv
// Transaction engine: position counter, control, address and data
// registers, acknowledge flag, and the stored bus levels.
// Assumes events come from srs_event_decode for the same cycle.
module srs_engine
    import srs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic [BYTE_W-1:0] rom_addr_o,
    output logic              line_scl_o,
    output logic              line_sda_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o
);

    localparam int CMD_END  = BYTE_W + 1;
    localparam int LAST_END = 2 * BYTE_W + 1;

    logic              scl_q, sda_q, ack_q;
    logic [TICK_W-1:0] tick_q;
    logic [BYTE_W-1:0] cmd_q, addr_q, data_q;

    logic              sda_n, ack_n;
    logic [TICK_W-1:0] tick_n, tick_inc;
    logic [BYTE_W-1:0] cmd_n, addr_n, data_n, addr_shift;
    logic              idle;

    assign idle       = (tick_q == '0) && !ack_q;
    assign tick_inc   = tick_q + 1'b1;
    assign addr_shift = {addr_q[BYTE_W-2:0], sda_i};
    assign rom_addr_o = addr_shift;

    // Work out the next register values for this event.
    always_comb begin
        sda_n  = sda_i;
        ack_n  = ack_q;
        tick_n = tick_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        data_n = data_q;
        if (ev_i == EV_START) begin
            tick_n = TICK_W'(1);
            cmd_n  = '0;
        end else if (ev_i == EV_STOP || idle) begin
            // levels recorded only
        end else if (ev_i == EV_RISE_SAME || ev_i == EV_RISE_CHG) begin
            if (ack_q) begin
                sda_n = 1'b0;
                ack_n = 1'b0;
            end else if (ev_i == EV_RISE_SAME) begin
                if (tick_q < TICK_W'(CMD_END)) begin
                    cmd_n  = {cmd_q[BYTE_W-2:0], sda_i};
                    tick_n = tick_inc;
                    if (tick_inc == TICK_W'(CMD_END))
                        ack_n = 1'b1;
                end else begin
                    if (cmd_q[0])
                        sda_n = data_q[BYTE_W-1];
                    addr_n = addr_shift;
                    data_n = data_q << 1;
                    tick_n = tick_inc;
                    if (tick_inc == TICK_W'(LAST_END)) begin
                        data_n = rom_data_i;
                        ack_n  = 1'b1;
                        tick_n = '0;
                    end
                end
            end
        end
    end

    // Register the state on each update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            ack_q  <= 1'b0;
            tick_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (ev_i != EV_NONE) begin
            scl_q  <= scl_i;
            sda_q  <= sda_n;
            ack_q  <= ack_n;
            tick_q <= tick_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            data_q <= data_n;
        end
    end

    assign line_scl_o = scl_q;
    assign line_sda_o = sda_q;
    assign tick_o     = tick_q;
    assign ack_o      = ack_q;

endmodule

// File: rtl/serial_rom_slave.sv
// Top level of the serial ROM responder: decoder, engine and constant store.
// Assumes the master presents levels only through the update strobe.
module serial_rom_slave #(
    parameter int BYTE_W = 8,
    parameter int SEED   = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);
    import srs_pkg::*;

    localparam int TICK_W = $clog2(2 * BYTE_W + 2);

    bus_ev_t           ev;
    logic              line_scl, line_sda, ack_w;
    logic [TICK_W-1:0] tick_w;
    logic [BYTE_W-1:0] rom_addr, rom_data;

    srs_event_decode i_decode (
        .upd_i    (upd_i),
        .prev_scl (line_scl),
        .prev_sda (line_sda),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev_o     (ev)
    );

    srs_rom #(.BYTE_W(BYTE_W), .SEED(SEED)) i_rom (
        .addr_i (rom_addr),
        .data_o (rom_data)
    );

    srs_engine #(.BYTE_W(BYTE_W), .TICK_W(TICK_W)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .rom_data_i (rom_data),
        .rom_addr_o (rom_addr),
        .line_scl_o (line_scl),
        .line_sda_o (line_sda),
        .tick_o     (tick_w),
        .ack_o      (ack_w)
    );

    assign sda_o = line_sda;

endmodule

// File: rtl/srs_checker.sv
// Property checker for serial_rom_slave, attached by bind.
// Assumes it observes the stored levels, counter and acknowledge flag.
module srs_checker #(
    parameter int TICK_W = 5,
    parameter int LAST   = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_i,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_o,
    input logic              line_scl,
    input logic              line_sda,
    input logic [TICK_W-1:0] tick_w,
    input logic              ack_w
);

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && scl_i && line_scl && line_sda && !sda_i) |=> (tick_w == TICK_W'(1)));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && tick_w == '0 && !ack_w && !(scl_i && line_scl)) |=> (tick_w == '0 && !ack_w));

    p_ack_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && scl_i && !line_scl && ack_w) |=> (!sda_o && !ack_w));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(sda_o) && $stable(tick_w) && $stable(ack_w)));

    p_cmd_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && tick_w == TICK_W'(8) && !ack_w && !line_scl && scl_i && line_sda == sda_i)
        |=> (ack_w && tick_w == TICK_W'(9)));

    p_tick_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_w < TICK_W'(LAST));

    p_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && scl_i && line_scl) |=> (sda_o == $past(sda_i)));

endmodule

bind serial_rom_slave srs_checker #(.TICK_W(TICK_W), .LAST(2 * BYTE_W + 1)) u_srs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_o    (sda_o),
    .line_scl (line_scl),
    .line_sda (line_sda),
    .tick_w   (tick_w),
    .ack_w    (ack_w)
);

// File: tb/test_serial_rom_slave.sv
module test_serial_rom_slave;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_i = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
    logic sda_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // behavioural reference state (after the most recent driven update)
    int m_scl = 1, m_sda = 1, m_tick = 0, m_cmd = 0, m_addr = 0, m_data = 0, m_ack = 0;
    string phase = "R2";
    int obs = 1;

    always #10 clk = ~clk;  // 50 MHz

    serial_rom_slave i_serial_rom_slave (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o)
    );

    function automatic int rom_ref(int a);  // R1 content formula
        return (a * 29 + 90) % 256;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(int u, int c, int d);
        int rec;
        if (u == 0) return;
        rec = d;
        if (m_scl == 1 && c == 1 && m_sda != d) begin
            if (d == 0) begin m_tick = 1; m_cmd = 0; end
        end else if (m_tick == 0 && m_ack == 0) begin
        end else if (m_scl == 0 && c == 1) begin
            if (m_ack == 1) begin
                rec = 0; m_ack = 0;
            end else if (m_sda == d) begin
                if (m_tick < 9) begin
                    m_cmd = ((m_cmd * 2) + d) % 256;
                    m_tick++;
                    if (m_tick == 9) m_ack = 1;
                end else begin
                    if (m_cmd % 2 == 1) rec = m_data / 128;
                    m_addr = ((m_addr * 2) + d) % 256;
                    m_data = (m_data * 2) % 256;
                    m_tick++;
                    if (m_tick == 17) begin
                        m_data = rom_ref(m_addr); m_ack = 1; m_tick = 0;
                    end
                end
            end
        end
        m_scl = c;
        m_sda = rec;
    endtask

    // one clock: compare against the model, then drive the next update
    task automatic apply(int u, int c, int d);
        @(negedge clk);
        obs = int'(sda_o);
        check(phase, obs, m_sda);
        upd_i = u[0]; scl_i = c[0]; sda_i = d[0];
        model(u, c, d);
    endtask

    task automatic send_bit(int b, output int seen);
        apply(1, 0, b);
        apply(1, 1, b);
        apply(1, 0, b);   // sample here shows the level after the rise
        seen = obs;
    endtask

    task automatic send_byte(int b, output int got);
        int s;
        got = 0;
        for (int i = 7; i >= 0; i--) begin
            send_bit((b >> i) & 1, s);
            got = got * 2 + s;
        end
    endtask

    task automatic do_start();
        apply(1, 0, 1); apply(1, 1, 1); apply(1, 1, 0); apply(1, 0, 0);
    endtask

    task automatic do_stop();
        apply(1, 0, 0); apply(1, 1, 0); apply(1, 1, 1);
    endtask

    task automatic read_txn(int ctl, int adr, output int got);
        int s, dummy;
        do_start();
        send_byte(ctl, dummy);
        send_bit(1, s); check("R7 ack after control", s, 0);
        send_byte(adr, got);
        send_bit(1, s); check("R10 ack after address", s, 0);
        do_stop();
    endtask

    initial begin
        int got, s, dummy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset sda_o", int'(sda_o), 1);

        // R3: strobe low, lines toggle
        phase = "R3";
        for (int i = 0; i < 6; i++) apply(0, i % 2, (i / 2) % 2);
        check("R3 sda_o held", int'(sda_o), 1);

        // R5: clocking with no START is only echoed
        phase = "R5";
        send_byte(8'hA1, got);
        check("R5 idle echo", got, 8'hA1);
        s = 0; send_bit(1, s); check("R5 no ack when idle", s, 1);

        // R9: first read returns reset data register
        phase = "R9";
        read_txn(8'hA1, 8'h3C, got);
        check("R9 first read shifts zero", got, 0);

        // R10: second read returns byte loaded at 0x3C
        phase = "R10";
        read_txn(8'hA1, 8'h07, got);
        check("R10 data of previous address", got, rom_ref(8'h3C));

        // R8: write mode echoes master bits, still loads address 0xFF
        phase = "R8";
        read_txn(8'hA0, 8'hFF, got);
        check("R8 write mode echo", got, 8'hFF);
        read_txn(8'hA1, 8'h00, got);
        check("R1 byte at top address", got, rom_ref(8'hFF));

        // R6: data change together with rising clock is not taken
        phase = "R6";
        do_start();
        apply(1, 0, 0); apply(1, 1, 1); apply(1, 0, 1);
        send_byte(8'hA1, dummy);
        send_bit(1, s); check("R6 ack still at bit nine", s, 0);
        send_byte(8'h80, got);
        check("R6 read of byte 0x00", got, rom_ref(8'h00));
        send_bit(1, s);
        do_stop();

        // R4: repeated START mid-byte restarts the control byte
        phase = "R4";
        do_start();
        send_bit(0, s); send_bit(1, s); send_bit(1, s);
        apply(1, 1, 1); apply(1, 1, 0); apply(1, 0, 0);
        send_byte(8'hA1, dummy);
        send_bit(1, s); check("R4 ack after restart", s, 0);
        send_byte(8'h11, got);
        check("R4 read of byte 0x80", got, rom_ref(8'h80));
        send_bit(1, s);
        do_stop();
        read_txn(8'hA1, 8'h22, got);
        check("R11 read of byte 0x11", got, rom_ref(8'h11));

        phase = "R11";
        apply(0, 1, 1); apply(0, 1, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule